// File: doc/BRIEF.md
# SDRAM Full-Page Burst Sequencer

This block drives one 16-bit single-data-rate SDRAM device. It uses nothing but full-page bursts, and it cuts each burst to the requested length with a burst-terminate command. After reset it holds clock-enable high and keeps the device deselected for a power-up wait. It then waits for a request. The request gives a direction, a size in 16-byte groups and a byte address with bit 0 dropped.

Each accepted request runs a fixed preamble: precharge all banks, load the mode register and auto-refresh. No refresh timer runs between transfers, so this preamble is the only refresh the device gets. The block then opens the addressed row and issues a read or write at the addressed column. It moves eight 16-bit words per group and ends the burst. Write data is requested one word per cycle through `wr_req_o` and is taken from `wdata_i` in that same cycle. Read data leaves the block with a valid strobe. `done_o` marks the end of the transfer.

The parameter `IO_REG` adds a register stage on every SDRAM output and on `sd_dq_i`. This moves every SDRAM pin one cycle later. The read valid strobe moves two cycles later, so streaming stays aligned. With the defaults the read data reaches `rdata_o` three cycles after the read command, which is CAS latency 3.

Top module: `sdram_fpb_seq`

## Requirements
- R1: While reset is asserted, `sd_cke_o` is low and `sd_cs_no` is high. From the first clock edge after reset release, `sd_cke_o` is high. For the first INIT_CYCLES edges after reset release, no command is issued (`sd_cs_no` stays high) and `start_i` is ignored.
- R2: Take cycle 0 as the cycle after the edge that accepts a request. Precharge-all (with `sd_a_o[10]`=1) is issued in cycle 0, mode set in cycle 2 and auto-refresh in cycle 4. Activate is issued TRFC+1 cycles after the auto-refresh.
- R3: The mode-set command carries `sd_a_o`=13'h037 and `sd_ba_o`=0. In this value, bits [2:0]=111 select a full-page burst, bit 3=0 selects sequential order and bits [6:4]=011 select CAS latency 3.
- R4: Activate drives `sd_ba_o`=addr[24:23] and `sd_a_o`=addr[22:10]. The column command comes TRCD cycles later with the same bank, `sd_a_o[8:0]`=addr[9:1] and `sd_a_o[12:9]`=0 (no auto-precharge).
- R5: The command codes on {cs,ras,cas,we} are: precharge 0010, mode set 0000, auto-refresh 0001, activate 0011, read 0101, write 0100, burst-terminate 0110. Deselect is 1111, with `sd_ba_o` and `sd_a_o` at 0. Every command cycle is followed by a deselect cycle.
- R6: Let N be 8 × `groups_i`. On a write, `wr_req_o` and `sd_dq_oe_o` are high in the write-command cycle and the N-1 cycles after it. In those cycles, `sd_dq_o` equals `wdata_i` of the same cycle.
- R7: On a read, `rd_valid_o` is high for N consecutive cycles, starting 3 cycles after the read command. In each of those cycles `rdata_o` equals `sd_dq_i` of that cycle.
- R8: Burst-terminate (0110) is issued N cycles after the column command in both directions. `sd_dq_oe_o` is low in that cycle.
- R9: `done_o` is high for exactly one cycle. For a write it is the cycle after burst-terminate. For a read it is the cycle after the last `rd_valid_o`. A `start_i` seen in the `done_o` cycle is accepted.
- R10: A `start_i` with `groups_i`=0 is ignored, and so is a `start_i` while a transfer is running. Neither one issues any command or `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| write_i | input | 1 | 1 = write to SDRAM, 0 = read |
| groups_i | input | GROUP_W | Transfer size in 16-byte groups (1..64) |
| addr_i | input | 24 | Byte address bits [24:1] |
| wdata_i | input | 16 | Write word, used in cycles with wr_req_o high |
| wr_req_o | output | 1 | Write word taken this cycle |
| rdata_o | output | 16 | Read word |
| rd_valid_o | output | 1 | rdata_o holds a burst word |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_no | output | 1 | SDRAM chip select, active low |
| sd_ras_no | output | 1 | SDRAM row strobe, active low |
| sd_cas_no | output | 1 | SDRAM column strobe, active low |
| sd_we_no | output | 1 | SDRAM write enable, active low |
| sd_ba_o | output | 2 | SDRAM bank address |
| sd_a_o | output | 13 | SDRAM address bus |
| sd_dq_o | output | 16 | SDRAM data out |
| sd_dq_oe_o | output | 1 | SDRAM data output enable |
| sd_dq_i | input | 16 | SDRAM data in |

## Verification
A wrong sequencer state shows on the command pins within one cycle. The symptoms are a missing deselect, a command in the wrong slot of the preamble, or a wrong address field on activate or column. The per-cycle model catches this on the same clock. A word counter that is off by one moves burst-terminate and the edge of the write enable by one cycle, and it changes the `done_o` cycle. A read delay line of the wrong length moves `rd_valid_o` against the data that the bench changes every cycle. Both faults are therefore visible within the transfer in which they occur.

// File: rtl/sdram_fpb_pkg.sv
package sdram_fpb_pkg;

  typedef struct packed {
    logic        cs_n;
    logic        ras_n;
    logic        cas_n;
    logic        we_n;
    logic [1:0]  ba;
    logic [12:0] a;
  } sd_cmd_t;

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE, ST_PRE, ST_PRE_G, ST_MRS, ST_MRS_G, ST_REF, ST_REF_G,
    ST_ACT, ST_ACT_G, ST_XFER, ST_TERM, ST_DRAIN
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] OP_DESEL = 4'b1111;
  localparam logic [3:0] OP_PRE   = 4'b0010;
  localparam logic [3:0] OP_MRS   = 4'b0000;
  localparam logic [3:0] OP_REF   = 4'b0001;
  localparam logic [3:0] OP_ACT   = 4'b0011;
  localparam logic [3:0] OP_RD    = 4'b0101;
  localparam logic [3:0] OP_WR    = 4'b0100;
  localparam logic [3:0] OP_BST   = 4'b0110;

  // full-page burst, sequential, CAS latency 3
  localparam logic [12:0] MODE_WORD = 13'h037;

  function automatic sd_cmd_t make_cmd(input logic [3:0] op, input logic [1:0] ba,
                                       input logic [12:0] a);
    sd_cmd_t c;
    c.cs_n  = op[3];
    c.ras_n = op[2];
    c.cas_n = op[1];
    c.we_n  = op[0];
    c.ba    = ba;
    c.a     = a;
    return c;
  endfunction

  function automatic int max_of(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sdram_fpb_ctrl.sv
module sdram_fpb_ctrl
  import sdram_fpb_pkg::*;
#(
  parameter int INIT_CYCLES = 6000,
  parameter int TRFC        = 8,
  parameter int TRCD        = 2,
  parameter int GROUP_W     = 7,
  parameter int LAT         = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               write_i,
  input  logic [GROUP_W-1:0] groups_i,
  input  logic [24:1]        addr_i,
  output sd_cmd_t            cmd_o,
  output logic               wr_beat_o,
  output logic               rd_beat_o,
  output logic               done_o,
  output logic               cke_o
);

  localparam int WAIT_MAX = max_of(max_of(INIT_CYCLES, TRFC), max_of(TRCD, LAT));
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam int WCW      = GROUP_W + 3;

  seq_state_e         state_q, state_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [WCW-1:0]     wcnt_q, wcnt_d;
  logic               first_q, first_d;
  logic               done_q, done_d;
  logic               cke_q;
  logic               accept;
  logic               wr_q;
  logic [GROUP_W-1:0] groups_q;
  logic [24:1]        addr_q;
  logic [WCW-1:0]     nwords;

  assign nwords = {groups_q, 3'b000};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    first_d = first_q;
    done_d  = 1'b0;
    accept  = 1'b0;
    cmd_o   = make_cmd(OP_DESEL, 2'b00, 13'h0000);
    unique case (state_q)
      ST_INIT: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - CW'(1);
      end
      ST_IDLE: begin
        if (start_i && (groups_i != '0)) begin
          accept  = 1'b1;
          state_d = ST_PRE;
        end
      end
      ST_PRE: begin
        cmd_o   = make_cmd(OP_PRE, 2'b00, 13'h0400);
        state_d = ST_PRE_G;
      end
      ST_PRE_G: state_d = ST_MRS;
      ST_MRS: begin
        cmd_o   = make_cmd(OP_MRS, 2'b00, MODE_WORD);
        state_d = ST_MRS_G;
      end
      ST_MRS_G: state_d = ST_REF;
      ST_REF: begin
        cmd_o   = make_cmd(OP_REF, 2'b00, 13'h0000);
        state_d = ST_REF_G;
        cnt_d   = CW'(TRFC - 1);
      end
      ST_REF_G: begin
        if (cnt_q == '0) state_d = ST_ACT;
        else             cnt_d   = cnt_q - CW'(1);
      end
      ST_ACT: begin
        cmd_o   = make_cmd(OP_ACT, addr_q[24:23], addr_q[22:10]);
        state_d = ST_ACT_G;
        cnt_d   = CW'(TRCD - 2);
      end
      ST_ACT_G: begin
        if (cnt_q == '0) begin
          state_d = ST_XFER;
          wcnt_d  = '0;
          first_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_XFER: begin
        if (first_q)
          cmd_o = make_cmd(wr_q ? OP_WR : OP_RD, addr_q[24:23], {4'b0000, addr_q[9:1]});
        first_d = 1'b0;
        wcnt_d  = wcnt_q + WCW'(1);
        if (wcnt_q == nwords - WCW'(1)) state_d = ST_TERM;
      end
      ST_TERM: begin
        cmd_o = make_cmd(OP_BST, 2'b00, 13'h0000);
        if (wr_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_DRAIN;
          cnt_d   = CW'(LAT - 2);
        end
      end
      ST_DRAIN: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_INIT;
      cnt_q    <= CW'(INIT_CYCLES - 1);
      wcnt_q   <= '0;
      first_q  <= 1'b0;
      done_q   <= 1'b0;
      cke_q    <= 1'b0;
      wr_q     <= 1'b0;
      groups_q <= '0;
      addr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wcnt_q  <= wcnt_d;
      first_q <= first_d;
      done_q  <= done_d;
      cke_q   <= 1'b1;
      if (accept) begin
        wr_q     <= write_i;
        groups_q <= groups_i;
        addr_q   <= addr_i;
      end
    end
  end

  assign wr_beat_o = (state_q == ST_XFER) &&  wr_q;
  assign rd_beat_o = (state_q == ST_XFER) && !wr_q;
  assign done_o    = done_q;
  assign cke_o     = cke_q;

endmodule

// File: rtl/sdram_fpb_io.sv
module sdram_fpb_io
  import sdram_fpb_pkg::*;
#(
  parameter int IO_REG = 0,
  parameter int LAT    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  sd_cmd_t     cmd_i,
  input  logic        oe_i,
  input  logic [15:0] wdata_i,
  input  logic        rd_beat_i,
  input  logic [15:0] sd_dq_i,
  output sd_cmd_t     cmd_o,
  output logic        oe_o,
  output logic [15:0] dq_o,
  output logic        rd_valid_o,
  output logic [15:0] rdata_o
);

  logic [LAT-1:0] beat_sr;

  // read strobe follows the column command by the full round trip
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_sr <= '0;
    else         beat_sr <= {beat_sr[LAT-2:0], rd_beat_i};
  end
  assign rd_valid_o = beat_sr[LAT-1];

  if (IO_REG != 0) begin : g_reg
    sd_cmd_t     cmd_q;
    logic        oe_q;
    logic [15:0] dq_q;
    logic [15:0] din_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_q <= make_cmd(OP_DESEL, 2'b00, 13'h0000);
        oe_q  <= 1'b0;
        dq_q  <= '0;
        din_q <= '0;
      end else begin
        cmd_q <= cmd_i;
        oe_q  <= oe_i;
        dq_q  <= wdata_i;
        din_q <= sd_dq_i;
      end
    end
    assign cmd_o   = cmd_q;
    assign oe_o    = oe_q;
    assign dq_o    = dq_q;
    assign rdata_o = din_q;
  end else begin : g_pass
    assign cmd_o   = cmd_i;
    assign oe_o    = oe_i;
    assign dq_o    = wdata_i;
    assign rdata_o = sd_dq_i;
  end

endmodule

// File: rtl/sdram_fpb_seq.sv
module sdram_fpb_seq
  import sdram_fpb_pkg::*;
#(
  parameter int INIT_CYCLES = 6000,
  parameter int TRFC        = 8,
  parameter int TRCD        = 2,
  parameter int GROUP_W     = 7,
  parameter int IO_REG      = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               write_i,
  input  logic [GROUP_W-1:0] groups_i,
  input  logic [24:1]        addr_i,
  input  logic [15:0]        wdata_i,
  output logic               wr_req_o,
  output logic [15:0]        rdata_o,
  output logic               rd_valid_o,
  output logic               done_o,
  output logic               sd_cke_o,
  output logic               sd_cs_no,
  output logic               sd_ras_no,
  output logic               sd_cas_no,
  output logic               sd_we_no,
  output logic [1:0]         sd_ba_o,
  output logic [12:0]        sd_a_o,
  output logic [15:0]        sd_dq_o,
  output logic               sd_dq_oe_o,
  input  logic [15:0]        sd_dq_i
);

  localparam int LAT = 3 + 2 * IO_REG;

  sd_cmd_t core_cmd, pin_cmd;
  logic    wr_beat, rd_beat;

  sdram_fpb_ctrl #(
    .INIT_CYCLES(INIT_CYCLES), .TRFC(TRFC), .TRCD(TRCD), .GROUP_W(GROUP_W), .LAT(LAT)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .write_i   (write_i),
    .groups_i  (groups_i),
    .addr_i    (addr_i),
    .cmd_o     (core_cmd),
    .wr_beat_o (wr_beat),
    .rd_beat_o (rd_beat),
    .done_o    (done_o),
    .cke_o     (sd_cke_o)
  );

  sdram_fpb_io #(.IO_REG(IO_REG), .LAT(LAT)) i_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (core_cmd),
    .oe_i       (wr_beat),
    .wdata_i    (wdata_i),
    .rd_beat_i  (rd_beat),
    .sd_dq_i    (sd_dq_i),
    .cmd_o      (pin_cmd),
    .oe_o       (sd_dq_oe_o),
    .dq_o       (sd_dq_o),
    .rd_valid_o (rd_valid_o),
    .rdata_o    (rdata_o)
  );

  assign wr_req_o  = wr_beat;
  assign sd_cs_no  = pin_cmd.cs_n;
  assign sd_ras_no = pin_cmd.ras_n;
  assign sd_cas_no = pin_cmd.cas_n;
  assign sd_we_no  = pin_cmd.we_n;
  assign sd_ba_o   = pin_cmd.ba;
  assign sd_a_o    = pin_cmd.a;

endmodule

// File: rtl/sdram_fpb_chk.sv
module sdram_fpb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sd_cke_o,
  input logic        sd_cs_no,
  input logic        sd_ras_no,
  input logic        sd_cas_no,
  input logic        sd_we_no,
  input logic [1:0]  sd_ba_o,
  input logic [12:0] sd_a_o,
  input logic        sd_dq_oe_o,
  input logic        rd_valid_o,
  input logic        done_o
);

  logic [3:0] op;
  assign op = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};

  AST_CKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sd_cke_o)); // R1

  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'b0010) |-> sd_a_o[10]); // R2

  AST_MODE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'b0000) |-> (sd_a_o == 13'h037 && sd_ba_o == 2'b00)); // R3

  AST_COL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'b0101 || op == 4'b0100) |-> (sd_a_o[12:9] == 4'b0000)); // R4

  AST_DESEL_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_cs_no |=> sd_cs_no); // R5

  AST_OE_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_dq_oe_o) |-> (op == 4'b0100)); // R6

  AST_NO_READ_WHILE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !sd_dq_oe_o); // R7

  AST_OE_DROP_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_dq_oe_o) |-> (op == 4'b0110)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

endmodule

bind sdram_fpb_seq sdram_fpb_chk i_sdram_fpb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sd_cke_o   (sd_cke_o),
  .sd_cs_no   (sd_cs_no),
  .sd_ras_no  (sd_ras_no),
  .sd_cas_no  (sd_cas_no),
  .sd_we_no   (sd_we_no),
  .sd_ba_o    (sd_ba_o),
  .sd_a_o     (sd_a_o),
  .sd_dq_oe_o (sd_dq_oe_o),
  .rd_valid_o (rd_valid_o),
  .done_o     (done_o)
);

// File: tb/test_sdram_fpb_seq.sv
module test_sdram_fpb_seq;

  localparam int INIT = 6000;
  localparam int TRFC = 8;
  localparam int TRCD = 2;
  localparam int GW   = 7;
  localparam int KACT = 5 + TRFC;
  localparam int KCOL = KACT + TRCD;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni, start_i, write_i;
  logic [GW-1:0] groups_i;
  logic [24:1]   addr_i;
  logic [15:0]   wdata_i = 16'h0, sd_dq_i = 16'h0;
  logic          wr_req_o, rd_valid_o, done_o;
  logic [15:0]   rdata_o, sd_dq_o;
  logic          sd_cke_o, sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no, sd_dq_oe_o;
  logic [1:0]    sd_ba_o;
  logic [12:0]   sd_a_o;

  sdram_fpb_seq i_sdram_fpb_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .groups_i(groups_i), .addr_i(addr_i), .wdata_i(wdata_i), .wr_req_o(wr_req_o),
    .rdata_o(rdata_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
    .sd_cke_o(sd_cke_o), .sd_cs_no(sd_cs_no), .sd_ras_no(sd_ras_no),
    .sd_cas_no(sd_cas_no), .sd_we_no(sd_we_no), .sd_ba_o(sd_ba_o), .sd_a_o(sd_a_o),
    .sd_dq_o(sd_dq_o), .sd_dq_oe_o(sd_dq_oe_o), .sd_dq_i(sd_dq_i)
  );

  int checks = 0, fails = 0, cyc = 0, ne = 0;

  // reference model state
  bit         act = 0, mwr = 0;
  int         k = 0, n = 0, kend = 0;
  logic [24:1] mad = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cyc=%0d actual=%h expected=%h", req, what, cyc, actual, expected);
    end
  endtask

  task automatic compare();
    logic [3:0]  e_op = 4'b1111;
    logic [1:0]  e_ba = 2'b00;
    logic [12:0] e_a  = 13'h0;
    bit e_oe = 0, e_rv = 0, e_done = 0, e_cke;
    string tag = (ne <= INIT) ? "R1" : "R5";
    e_cke = (ne >= 1);
    if (act) begin
      if (k == 0)        begin e_op = 4'b0010; e_a = 13'h0400; tag = "R2"; end
      else if (k == 2)   begin e_op = 4'b0000; e_a = 13'h0037; tag = "R3"; end
      else if (k == 4)   begin e_op = 4'b0001; tag = "R2"; end
      else if (k == KACT) begin e_op = 4'b0011; e_ba = mad[24:23]; e_a = mad[22:10]; tag = "R4"; end
      else if (k == KCOL) begin
        e_op = mwr ? 4'b0100 : 4'b0101; e_ba = mad[24:23]; e_a = {4'b0, mad[9:1]}; tag = "R4";
      end else if (k == KCOL + n) begin e_op = 4'b0110; tag = "R8"; end
      e_oe   = mwr && k >= KCOL && k < KCOL + n;
      e_rv   = !mwr && k >= KCOL + 3 && k < KCOL + n + 3;
      e_done = (k == kend);
    end
    chk({sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no, sd_ba_o, sd_a_o} == {e_op, e_ba, e_a},
        tag, "cmd", {13'h0, sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no, sd_ba_o, sd_a_o},
        {13'h0, e_op, e_ba, e_a});
    chk(sd_cke_o == e_cke, "R1", "cke", 32'(sd_cke_o), 32'(e_cke));
    chk(sd_dq_oe_o == e_oe && wr_req_o == e_oe, (act && k == KCOL + n) ? "R8" : "R6",
        "oe/req", {30'h0, sd_dq_oe_o, wr_req_o}, {30'h0, e_oe, e_oe});
    if (e_oe) chk(sd_dq_o == wdata_i, "R6", "dq_o", 32'(sd_dq_o), 32'(wdata_i));
    chk(rd_valid_o == e_rv, "R7", "rd_valid", 32'(rd_valid_o), 32'(e_rv));
    if (e_rv) chk(rdata_o == sd_dq_i, "R7", "rdata", 32'(rdata_o), 32'(sd_dq_i));
    chk(done_o == e_done, "R9", "done", 32'(done_o), 32'(e_done));
  endtask

  always @(posedge clk) begin
    if (rst_ni) begin
      ne++;
      if (act && k < kend) k++;
      else begin
        act = 0;
        if (ne > INIT && start_i && groups_i != '0) begin
          act = 1; k = 0; n = 8 * int'(groups_i); mwr = write_i; mad = addr_i;
          kend = mwr ? KCOL + n + 1 : KCOL + n + 3;
        end
      end
    end
    #1;
    cyc++;
    wdata_i = 16'(cyc * 37 + 5);
    sd_dq_i = 16'(cyc * 91) ^ 16'h5a5a;
    #5;
    compare();
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic issue(input bit wr, input int g, input logic [24:1] ad);
    start_i = 1; write_i = wr; groups_i = GW'(g); addr_i = ad;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done_o !== 1'b1);
  endtask

  // R10: after an ignored start, no command and no done
  task automatic quiet_window(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(sd_cs_no == 1'b1 && done_o == 1'b0, "R10", "ignored start",
          {30'h0, sd_cs_no, done_o}, 32'h2);
    end
  endtask

  initial begin
    rst_ni = 0; start_i = 0; write_i = 0; groups_i = '0; addr_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cke_o == 0 && sd_cs_no == 1 && sd_dq_oe_o == 0 && done_o == 0, "R1", "reset",
        {28'h0, sd_cke_o, sd_cs_no, sd_dq_oe_o, done_o}, 32'h4);
    rst_ni = 1;
    repeat (10) @(negedge clk);
    issue(1, 1, 24'h00_0040);          // R1: start during power-up wait
    while (ne <= INIT + 2) @(negedge clk);
    issue(1, 1, 24'hB3_5A7F);          // R6 single group write
    wait_done();
    @(negedge clk);
    issue(0, 2, 24'h4C_A5C3);          // R7 two-group read
    wait_done();
    @(negedge clk);
    issue(1, 0, 24'h12_3456);          // R10 zero size
    quiet_window(30);
    issue(1, 4, 24'hFF_FFFF);          // R4 top bank/row/column
    repeat (20) @(negedge clk);
    issue(0, 3, 24'h00_1111);          // R10 start while busy
    wait_done();
    issue(1, 1, 24'h80_0200);          // R9 back-to-back from done cycle
    wait_done();
    issue(0, 1, 24'h40_0101);
    wait_done();
    @(negedge clk);
    issue(1, 64, 24'h2A_0000);         // R8 full page
    wait_done();
    @(negedge clk);
    issue(0, 64, 24'h55_01FF);
    wait_done();
    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule